// File: doc/BRIEF.md
# Ranked-Slot Memory Port Arbiter

This block decides which of four requesters may use one shared external memory port. The requesters are a host processor, a DMA engine, an image buffer and a DSP host port. Software sets the ranking through a small write port. The port holds four rank slots, and each slot names one requester. When the port is free, the block looks through the slots from the top rank down. The first named requester that is asking wins, and it gets a one-hot grant.

A grant stays up until the memory side reports that the access has finished. The port then sits idle for one clock. Arbitration runs again on the clock after that, so the ranking is always applied to the requests current at that time. Only the grant lines are produced. Memory timing and data paths belong to other blocks.

Top module: `mem_port_arbiter`

## Requirements
- R1: After reset, no grant is asserted. The slots rank the requesters processor, DMA, image buffer, DSP, from highest to lowest.
- R2: Requester codes are 0 for the processor, 1 for DMA, 2 for the image buffer and 3 for the DSP. Grant bit n belongs to requester code n, and the same holds for request bit n. When the port is free, the winner is the highest-ranked slot whose named requester is asking. Its grant rises one clock after the requests are sampled.
- R3: No more than one grant bit is high in any clock.
- R4: An issued grant stays unchanged while `mem_done` is low, even if requests drop or a higher-ranked requester starts asking.
- R5: If `mem_done` is high at a clock edge while a grant is held, all grants are low after that edge. Arbitration on the next edge uses the requests present then.
- R6: A write with `cfg_we` high and `cfg_level` from 1 to 4 stores `cfg_id` into that rank. Level 1 is the highest rank. The new ranking applies from the next arbitration.
- R7: A write whose `cfg_level` is 0, 5, 6 or 7 is dropped and leaves the ranking unchanged.
- R8: If several slots name the same requester, the highest of them sets its rank. A requester named in no slot is never granted.
- R9: A grant is only issued to a requester whose request was high at the edge where the grant was issued.
- R10: `mem_done` has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Request lines, bit n = requester code n |
| mem_done | input | 1 | Memory side reports the current access finished |
| cfg_we | input | 1 | Rank-slot write strobe |
| cfg_level | input | 3 | Rank to write, 1 = highest, valid 1..4 |
| cfg_id | input | 2 | Requester code stored into the rank |
| grant | output | 4 | One-hot grant, bit n = requester code n |

## Verification
The hardest situation to reach is one where the ranking itself decides the outcome. That needs several requests contending at one arbitration edge, after software has reordered the slots, filled them with duplicates or left some requesters out. The stimulus first rewrites the slots into the reverse order. It then sends out-of-range writes that must leave that order alone. Next it loads duplicate codes so that two requesters appear in no slot, then raises all four requests and checks that the unnamed pair never wins. A handover sequence keeps a second request waiting through the done edge. This shows the idle clock and the fresh arbitration that follows it.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    RQ_CPU = 2'd0,
    RQ_DMA = 2'd1,
    RQ_IMG = 2'd2,
    RQ_DSP = 2'd3
  } rq_code_e;
endpackage

// File: rtl/rank_slots.sv
module rank_slots #(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 2,
  parameter int LVL_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [LVL_W-1:0]          cfg_level,
  input  logic [ID_W-1:0]           cfg_id,
  output logic [NUM_SLOTS*ID_W-1:0] slots_flat
);
  // level 1 is slot 0 (highest rank)
  function automatic logic level_in_range(input logic [LVL_W-1:0] lvl);
    return (int'(lvl) >= 1) && (int'(lvl) <= NUM_SLOTS);
  endfunction

  logic wr_accept;
  logic wr_reject;
  assign wr_accept = cfg_we && level_in_range(cfg_level);
  assign wr_reject = cfg_we && !level_in_range(cfg_level);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots_flat[s*ID_W +: ID_W] <= ID_W'(s);
      else if (wr_accept && (int'(cfg_level) == s + 1))
        slots_flat[s*ID_W +: ID_W] <= cfg_id;
    end
  end

  assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(slots_flat));

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> slots_flat[(int'($past(cfg_level)) - 1)*ID_W +: ID_W] == $past(cfg_id));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 2
) (
  input  logic [NUM_SLOTS*ID_W-1:0] slots_flat,
  input  logic [NUM_REQ-1:0]        req,
  output logic                      win_valid,
  output logic [ID_W-1:0]           win_id
);
  // scan from lowest rank up so the highest matching rank overwrites last
  function automatic logic [ID_W:0] pick(input logic [NUM_SLOTS*ID_W-1:0] sl,
                                         input logic [NUM_REQ-1:0] rq);
    logic [ID_W:0] res;
    logic [ID_W-1:0] code;
    res = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      code = sl[s*ID_W +: ID_W];
      if (rq[code]) res = {1'b1, code};
    end
    return res;
  endfunction

  logic [ID_W:0] pick_res;
  assign pick_res  = pick(slots_flat, req);
  assign win_valid = pick_res[ID_W];
  assign win_id    = pick_res[ID_W-1:0];

  always_comb begin
    if (win_valid) begin
      assert_winner_requesting_R2: assert (req[win_id]);
    end
  end
endmodule

// File: rtl/grant_hold.sv
module grant_hold #(
  parameter int NUM_REQ = 4,
  parameter int ID_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic               mem_done,
  input  logic               win_valid,
  input  logic [ID_W-1:0]    win_id,
  output logic [NUM_REQ-1:0] grant
);
  logic busy;
  logic issue;
  logic release_now;
  assign busy        = |grant;
  assign issue       = !busy && win_valid;
  assign release_now = busy && mem_done;

  always_ff @(posedge clk) begin
    if (!rst_n)           grant <= '0;
    else if (release_now) grant <= '0;
    else if (issue)       grant <= NUM_REQ'(1) << win_id;
  end

  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_hold_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_done) |=> $stable(grant));

  assert_drop_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> grant == '0);

  assert_grant_to_requester_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> |(grant & $past(req)));

  assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !win_valid) |=> grant == '0);
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = $clog2(NUM_REQ),
  parameter int LVL_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic               mem_done,
  input  logic               cfg_we,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic [ID_W-1:0]    cfg_id,
  output logic [NUM_REQ-1:0] grant
);
  logic [NUM_SLOTS*ID_W-1:0] slots_flat;
  logic                      win_valid;
  logic [ID_W-1:0]           win_id;

  rank_slots #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .LVL_W(LVL_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_level(cfg_level),
    .cfg_id(cfg_id), .slots_flat(slots_flat));

  prio_pick #(.NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_pick (
    .slots_flat(slots_flat), .req(req), .win_valid(win_valid), .win_id(win_id));

  grant_hold #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .req(req), .mem_done(mem_done),
    .win_valid(win_valid), .win_id(win_id), .grant(grant));
endmodule

// File: tb/test_mem_port_arbiter.sv
`timescale 1ns/1ps
module test_mem_port_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       mem_done = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_level = '0;
  logic [1:0] cfg_id = '0;
  logic [3:0] grant;

  int compared = 0;
  int mismatched = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] prev_g = '0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  mem_port_arbiter i_mem_port_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .mem_done(mem_done),
    .cfg_we(cfg_we), .cfg_level(cfg_level), .cfg_id(cfg_id), .grant(grant));

  task automatic check(input logic ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: grant actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: each newly issued grant is compared with the next queued item
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(grant) > 1) check(1'b0, "R3", grant, 4'b0000);
      if (grant != 0 && prev_g == 0) begin
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected grant", grant, 4'b0000);
        else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(grant == e, t, grant, e);
        end
      end
    end
    prev_g = grant;
  end

  task automatic expect_grant(input logic [3:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic run_txn(input logic [3:0] r, input logic [3:0] e, input string t);
    @(negedge clk);
    req = r;
    expect_grant(e, t);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (grant != 0) break;
    end
    mem_done = 1'b1;
    req = '0;
    @(negedge clk);
    mem_done = 1'b0;
    check(grant == 0, "R5", grant, 4'b0000);
  endtask

  task automatic write_slot(input logic [2:0] lvl, input logic [1:0] id);
    @(negedge clk);
    cfg_we = 1'b1; cfg_level = lvl; cfg_id = id;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant == 0, "R1 reset", grant, 4'b0000);

    // R1 default order, R2 ranking with mixed patterns
    run_txn(4'b1111, 4'b0001, "R1");
    run_txn(4'b1100, 4'b0100, "R2");
    run_txn(4'b1010, 4'b0010, "R2");

    // R4 grant held while done is low
    @(negedge clk);
    req = 4'b1000;
    expect_grant(4'b1000, "R4");
    @(negedge clk);
    req = 4'b0001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(grant == 4'b1000, "R4", grant, 4'b1000);
    end
    mem_done = 1'b1; req = '0;
    @(negedge clk);
    mem_done = 1'b0;

    // R5 idle clock then fresh arbitration
    @(negedge clk);
    req = 4'b0110;
    expect_grant(4'b0010, "R5");
    @(negedge clk);
    mem_done = 1'b1; req = 4'b0100;
    expect_grant(4'b0100, "R5");
    @(negedge clk);
    mem_done = 1'b0;
    check(grant == 0, "R5 idle", grant, 4'b0000);
    @(negedge clk);
    check(grant == 4'b0100, "R5 rearb", grant, 4'b0100);
    mem_done = 1'b1; req = '0;
    @(negedge clk);
    mem_done = 1'b0;

    // R6 reverse the ranking
    write_slot(3'd1, 2'd3);
    write_slot(3'd2, 2'd2);
    write_slot(3'd3, 2'd1);
    write_slot(3'd4, 2'd0);
    run_txn(4'b1111, 4'b1000, "R6");
    run_txn(4'b0011, 4'b0010, "R6");

    // R7 out-of-range levels dropped
    write_slot(3'd0, 2'd0);
    write_slot(3'd5, 2'd0);
    write_slot(3'd7, 2'd0);
    run_txn(4'b1111, 4'b1000, "R7");
    run_txn(4'b0111, 4'b0100, "R7");

    // R8 duplicates: slots become DMA, DMA, DMA, CPU
    write_slot(3'd1, 2'd1);
    write_slot(3'd2, 2'd1);
    run_txn(4'b1111, 4'b0010, "R8");
    @(negedge clk);
    req = 4'b1100;
    repeat (5) @(negedge clk);
    check(grant == 0, "R8 unnamed", grant, 4'b0000);
    req = '0;
    run_txn(4'b1101, 4'b0001, "R8");

    // R10 done while idle
    @(negedge clk);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    check(grant == 0, "R10 idle", grant, 4'b0000);
    @(negedge clk);
    req = 4'b0001; mem_done = 1'b1;
    expect_grant(4'b0001, "R10");
    @(negedge clk);
    mem_done = 1'b0;
    check(grant == 4'b0001, "R10", grant, 4'b0001);
    @(negedge clk);
    check(grant == 4'b0001, "R10 held", grant, 4'b0001);
    mem_done = 1'b1; req = '0;
    @(negedge clk);
    mem_done = 1'b0;
    @(negedge clk);
    check(exp_q.size() == 0, "R9 queue drained", 4'(exp_q.size()), 4'b0000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule